// File: doc/BRIEF.md
# Pipelined Memory-to-Memory Add/Subtract Core

This block is a minimal programmable calculator core. Its program is a stream of three-address instructions. Each instruction takes two words from data memory, adds or subtracts them, and stores the result at a third data-memory address. There are no registers, no constant loads and no branches. Any value an instruction produces reaches later instructions only by way of data memory.

The work is split into five single-cycle stages:

1. Fetch and decode.
2. Read the first operand.
3. Read the second operand.
4. Operate.
5. Write back.

A new instruction can enter every cycle. In one cycle the core therefore uses one instruction-memory read port, two data-memory read ports and one data-memory write port. Both memories sit outside the core. Their reads are combinational and the data-memory write is clocked.

Operands that an older in-flight instruction has not yet written are taken from the writeback stage by address compare. Results therefore match strictly sequential execution. The all-ones instruction word stops fetching. A done flag rises once every older instruction has written back. Two counters, elapsed cycles and retired instructions, make the fill latency and the throughput visible at the ports.

Top module: `mem2mem_calc_core`

## Requirements
- R1: An instruction word is laid out, from the most significant bit down, as a 1-bit opcode, then source address A, then source address B, then destination address C, each address ADDR_W bits wide. Opcode 0 stores A+B at C and opcode 1 stores A-B at C. Both wrap modulo 2^DATA_W.
- R2: After reset is released, the first instruction's write strobe is asserted in the fifth cycle, that is, after four rising edges. The retired count first reads 1 after the fifth edge.
- R3: With the pipeline full, exactly one instruction retires per cycle. After edge k, for 5 <= k <= N+4, the retired count equals k-4, where N is the number of instructions before the halt word.
- R4: An instruction that reads an address written by any older instruction, at any distance including 1, 2 and 3, sees the value that sequential execution gives. This holds for either operand and for both operands at once.
- R5: When several instructions write the same address, the youngest write is the value left in memory. An instruction may name the same address for A, B and C.
- R6: The all-ones word acts as halt. It performs no write, the fetch address stays on the halt word's address, and no instruction after it executes.
- R7: Done asserts in the cycle after the last older instruction writes back. It stays asserted until reset, and no write strobe occurs while it is high.
- R8: While reset is high, and after its release before the first edge, the fetch address is 0, the write strobe and done are low, and both counters read 0.
- R9: The cycle count rises by one on every edge at which done is low and holds once done is high. A run of N>0 instructions ends at N+4, and a halt at address 0 ends at 1.
- R10: The retired count rises by one for each write strobe and by nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imemAddr | output | PC_W | Instruction fetch address |
| imemData | input | 1+3*ADDR_W | Instruction word at imemAddr (combinational read) |
| rdAddrA | output | ADDR_W | First operand read address |
| rdDataA | input | DATA_W | Data at rdAddrA (combinational read) |
| rdAddrB | output | ADDR_W | Second operand read address |
| rdDataB | input | DATA_W | Data at rdAddrB (combinational read) |
| wrEn | output | 1 | Result write strobe |
| wrAddr | output | ADDR_W | Result write address |
| wrData | output | DATA_W | Result write data |
| done | output | 1 | Halted and pipeline drained |
| cycleCount | output | CNT_W | Cycles elapsed since reset until done |
| retiredCount | output | CNT_W | Instructions written back since reset |

## Verification
The bench uses the default parameters: 8-bit addresses, 16-bit data, an 8-bit fetch address and 16-bit counters. With 8-bit addresses, a 256-word data memory can be compared word by word against a sequential model after each program. With 16-bit data, values of 0xFFFF and 0 reach both wrap directions of the adder. Short programs place dependent instructions at distances 1 through 4 and repeat destination addresses, so every path through the writeback forwarding is used. A halt at address 0 and a trap word after each halt cover the drain and stop behaviour.

// File: rtl/calc_pkg.sv
package calc_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } calcOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wbValid;   // stage-5 slot holds a real instruction
  } pipeCtl_t;
endpackage

// File: rtl/calc_ctrl.sv
module calc_ctrl
  import calc_pkg::*;
#(
  parameter int PC_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             isHaltWord,
  output pipeCtl_t         ctl,
  output logic [PC_W-1:0]  fetchPc,
  output logic             done,
  output logic [CNT_W-1:0] cycleCount,
  output logic [CNT_W-1:0] retiredCount
);
  localparam int NUM_STAGES = 5;
  localparam int VLD_W      = NUM_STAGES - 1;  // valid bits for stages 2..5

  logic             halted;
  logic             issue;
  logic [VLD_W-1:0] stageValid;   // bit 0 = stage 2, top bit = stage 5

  assign issue       = !halted && !isHaltWord;
  assign done        = halted && (stageValid == '0);
  assign ctl.wbValid = stageValid[VLD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      halted       <= 1'b0;
      fetchPc      <= '0;
      stageValid   <= '0;
      cycleCount   <= '0;
      retiredCount <= '0;
    end else begin
      stageValid <= {stageValid[VLD_W-2:0], issue};
      if (!halted) begin
        if (isHaltWord) halted  <= 1'b1;
        else            fetchPc <= fetchPc + 1'b1;
      end
      if (!done)       cycleCount   <= cycleCount + 1'b1;
      if (ctl.wbValid) retiredCount <= retiredCount + 1'b1;
    end
  end
endmodule

// File: rtl/calc_datapath.sv
module calc_datapath
  import calc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  pipeCtl_t              ctl,
  input  logic [3*ADDR_W:0]     imemData,
  output logic                  isHaltWord,
  output logic [ADDR_W-1:0]     rdAddrA,
  input  logic [DATA_W-1:0]     rdDataA,
  output logic [ADDR_W-1:0]     rdAddrB,
  input  logic [DATA_W-1:0]     rdDataB,
  output logic                  wrEn,
  output logic [ADDR_W-1:0]     wrAddr,
  output logic [DATA_W-1:0]     wrData
);
  localparam int INSTR_W = 3*ADDR_W + 1;
  localparam int OP_BIT  = INSTR_W - 1;
  localparam int A_LSB   = 2*ADDR_W;
  localparam int B_LSB   = ADDR_W;

  // Stage 2 register: decoded instruction
  calcOp_e           s2Op;
  logic [ADDR_W-1:0] s2A, s2B, s2C;
  // Stage 3 register
  calcOp_e           s3Op;
  logic [ADDR_W-1:0] s3A, s3B, s3C;
  logic [DATA_W-1:0] s3AVal;
  // Stage 4 register
  calcOp_e           s4Op;
  logic [ADDR_W-1:0] s4A, s4B, s4C;
  logic [DATA_W-1:0] s4AVal, s4BVal;
  // Stage 5 register
  logic [ADDR_W-1:0] s5C;
  logic [DATA_W-1:0] s5Res;

  logic [DATA_W-1:0] aFix2, aFix3, bFix3, opA, opB, aluRes;

  // Patch a captured operand with the result now in writeback, if the address matches
  function automatic logic [DATA_W-1:0] wbPatch(
    input logic              hit,
    input logic [DATA_W-1:0] wbVal,
    input logic [DATA_W-1:0] oldVal
  );
    return hit ? wbVal : oldVal;
  endfunction

  assign isHaltWord = &imemData;
  assign rdAddrA    = s2A;
  assign rdAddrB    = s3B;

  assign aFix2 = wbPatch(ctl.wbValid && (s5C == s2A), s5Res, rdDataA);
  assign aFix3 = wbPatch(ctl.wbValid && (s5C == s3A), s5Res, s3AVal);
  assign bFix3 = wbPatch(ctl.wbValid && (s5C == s3B), s5Res, rdDataB);
  assign opA   = wbPatch(ctl.wbValid && (s5C == s4A), s5Res, s4AVal);
  assign opB   = wbPatch(ctl.wbValid && (s5C == s4B), s5Res, s4BVal);

  always_comb begin
    unique case (s4Op)
      OP_ADD:  aluRes = opA + opB;
      OP_SUB:  aluRes = opA - opB;
      default: aluRes = opA + opB;
    endcase
  end

  // Data registers advance every cycle; validity lives in the control
  always_ff @(posedge clk) begin
    s2Op   <= calcOp_e'(imemData[OP_BIT]);
    s2A    <= imemData[A_LSB +: ADDR_W];
    s2B    <= imemData[B_LSB +: ADDR_W];
    s2C    <= imemData[0 +: ADDR_W];

    s3Op   <= s2Op;
    s3A    <= s2A;
    s3B    <= s2B;
    s3C    <= s2C;
    s3AVal <= aFix2;

    s4Op   <= s3Op;
    s4A    <= s3A;
    s4B    <= s3B;
    s4C    <= s3C;
    s4AVal <= aFix3;
    s4BVal <= bFix3;

    s5C    <= s4C;
    s5Res  <= aluRes;
  end

  assign wrEn   = ctl.wbValid;
  assign wrAddr = s5C;
  assign wrData = s5Res;
endmodule

// File: rtl/mem2mem_calc_core.sv
module mem2mem_calc_core
  import calc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int PC_W   = 8,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  output logic [PC_W-1:0]     imemAddr,
  input  logic [3*ADDR_W:0]   imemData,
  output logic [ADDR_W-1:0]   rdAddrA,
  input  logic [DATA_W-1:0]   rdDataA,
  output logic [ADDR_W-1:0]   rdAddrB,
  input  logic [DATA_W-1:0]   rdDataB,
  output logic                wrEn,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [DATA_W-1:0]   wrData,
  output logic                done,
  output logic [CNT_W-1:0]    cycleCount,
  output logic [CNT_W-1:0]    retiredCount
);
  pipeCtl_t ctl;
  logic     isHaltWord;

  calc_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .isHaltWord   (isHaltWord),
    .ctl          (ctl),
    .fetchPc      (imemAddr),
    .done         (done),
    .cycleCount   (cycleCount),
    .retiredCount (retiredCount)
  );

  calc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .ctl        (ctl),
    .imemData   (imemData),
    .isHaltWord (isHaltWord),
    .rdAddrA    (rdAddrA),
    .rdDataA    (rdDataA),
    .rdAddrB    (rdAddrB),
    .rdDataB    (rdDataB),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData)
  );
endmodule

// File: rtl/calc_checker.sv
module calc_checker #(
  parameter int PC_W  = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [PC_W-1:0]  imemAddr,
  input logic             wrEn,
  input logic             done,
  input logic [CNT_W-1:0] cycleCount,
  input logic [CNT_W-1:0] retiredCount
);
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  p_no_write_when_done_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !wrEn);

  p_fetch_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(imemAddr));

  p_cycle_tick_r9: assert property (@(posedge clk) disable iff (rst)
    !done |=> cycleCount == $past(cycleCount) + 1'b1);

  p_cycle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(cycleCount));

  p_retire_on_write_r10: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> retiredCount == $past(retiredCount) + 1'b1);

  p_retire_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(retiredCount));

  // R8: reset state seen at the edge after a reset cycle
  p_reset_state_r8: assert property (@(posedge clk)
    $past(rst) |-> (imemAddr == '0 && !wrEn && !done && cycleCount == '0 && retiredCount == '0));
endmodule

bind mem2mem_calc_core calc_checker #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .imemAddr     (imemAddr),
  .wrEn         (wrEn),
  .done         (done),
  .cycleCount   (cycleCount),
  .retiredCount (retiredCount)
);

// File: tb/mem2mem_calc_core_bench.sv
`timescale 1ns/1ps
module mem2mem_calc_core_bench;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int PC_W    = 8;
  localparam int CNT_W   = 16;
  localparam int INSTR_W = 3*ADDR_W + 1;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int IDEPTH  = 1 << PC_W;
  localparam logic [INSTR_W-1:0] HALT = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  logic [PC_W-1:0]    imemAddr;
  logic [INSTR_W-1:0] imemData;
  logic [ADDR_W-1:0]  rdAddrA, rdAddrB, wrAddr;
  logic [DATA_W-1:0]  rdDataA, rdDataB, wrData;
  logic               wrEn, done;
  logic [CNT_W-1:0]   cycleCount, retiredCount;

  logic [INSTR_W-1:0] imem   [IDEPTH];
  logic [DATA_W-1:0]  dmem   [DEPTH];
  logic [DATA_W-1:0]  refMem [DEPTH];
  logic [INSTR_W-1:0] prog   [64];
  int                 progLen;
  int                 writeCount = 0;
  int                 tests = 0;
  int                 fails = 0;

  assign imemData = imem[imemAddr];
  assign rdDataA  = dmem[rdAddrA];
  assign rdDataB  = dmem[rdAddrB];

  always @(posedge clk) begin
    if (wrEn) begin
      dmem[wrAddr] <= wrData;
      writeCount   <= writeCount + 1;
    end
  end

  mem2mem_calc_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_W(PC_W), .CNT_W(CNT_W))
  u_mem2mem_calc_core (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .done(done),
    .cycleCount(cycleCount), .retiredCount(retiredCount)
  );

  function automatic logic [INSTR_W-1:0] mk(input logic op, input int a, input int b, input int c);
    return {op, ADDR_W'(a), ADDR_W'(b), ADDR_W'(c)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic seedData(input int salt);
    for (int i = 0; i < DEPTH; i++) dmem[i] = DATA_W'(i * 1031 + salt * 77);
  endtask

  // Reset, run the loaded program to done, compare with a sequential model
  task automatic runProg(input string name);
    int n, k, wr0, badAddr;
    logic [ADDR_W-1:0] a, b, c;
    logic [CNT_W-1:0] cyc0, ret0;
    logic [PC_W-1:0] pc0;
    n = progLen;
    for (int i = 0; i < IDEPTH; i++) imem[i] = mk(1'b0, 1, 1, 1);  // trap word: must never run
    for (int i = 0; i < n; i++) imem[i] = prog[i];
    imem[n] = HALT;
    for (int i = 0; i < DEPTH; i++) refMem[i] = dmem[i];
    for (int i = 0; i < n; i++) begin
      a = prog[i][2*ADDR_W +: ADDR_W];
      b = prog[i][ADDR_W +: ADDR_W];
      c = prog[i][0 +: ADDR_W];
      refMem[c] = prog[i][INSTR_W-1] ? DATA_W'(refMem[a] - refMem[b])
                                     : DATA_W'(refMem[a] + refMem[b]);
    end
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check(imemAddr == 0 && !wrEn && !done && cycleCount == 0 && retiredCount == 0,
          "R8", {name, " reset state"}, {imemAddr, cycleCount, retiredCount}, 0);
    rst = 1'b0;
    wr0 = writeCount;
    k = 0;
    while (!done && k < 1000) begin
      @(posedge clk); @(negedge clk); k++;
      if (n > 0 && k == 4)
        check(wrEn && wrAddr == prog[0][0 +: ADDR_W] && retiredCount == 0, "R2",
              {name, " first write strobe"}, {wrEn, retiredCount}, 64'h1_0000);
      if (n > 0 && k >= 5 && k <= n + 4)
        check(retiredCount == CNT_W'(k - 4), "R3", {name, " retire rate"}, retiredCount, k - 4);
    end
    check(done, "R7", {name, " done reached"}, done, 1);
    check(cycleCount == CNT_W'(n == 0 ? 1 : n + 4), "R9", {name, " final cycle count"},
          cycleCount, n == 0 ? 1 : n + 4);
    check(retiredCount == CNT_W'(n) && writeCount - wr0 == n, "R10", {name, " retired/writes"},
          retiredCount, n);
    check(imemAddr == PC_W'(n), "R6", {name, " fetch stops on halt"}, imemAddr, n);
    badAddr = -1;
    for (int i = 0; i < DEPTH; i++) if (badAddr < 0 && dmem[i] !== refMem[i]) badAddr = i;
    check(badAddr < 0, "R1", {name, " memory image (R4 R5 R6)"},
          badAddr < 0 ? 0 : dmem[badAddr], badAddr < 0 ? 0 : refMem[badAddr]);
    cyc0 = cycleCount; ret0 = retiredCount; pc0 = imemAddr; wr0 = writeCount;
    for (int i = 0; i < 6; i++) begin @(posedge clk); @(negedge clk); end
    check(done && cycleCount == cyc0 && retiredCount == ret0 && imemAddr == pc0 && writeCount == wr0,
          "R7", {name, " quiet after done"}, cycleCount, cyc0);
  endtask

  task automatic tReset();
    for (int i = 0; i < IDEPTH; i++) imem[i] = mk(1'b0, 3, 4, 5);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check(imemAddr == 0 && !wrEn && !done && cycleCount == 0 && retiredCount == 0,
          "R8", "reset hold", {imemAddr, cycleCount}, 0);
  endtask

  task automatic tArith();
    seedData(1);
    dmem[20] = 16'hFFFF; dmem[21] = 16'h0002; dmem[22] = 16'h0000; dmem[23] = 16'h0001;
    dmem[24] = 16'h1234; dmem[25] = 16'h0234;
    prog[0] = mk(1'b0, 20, 21, 100);   // wraps to 1 (R1)
    prog[1] = mk(1'b1, 22, 23, 101);   // wraps to FFFF (R1)
    prog[2] = mk(1'b1, 24, 25, 102);
    prog[3] = mk(1'b0, 24, 25, 103);
    prog[4] = mk(1'b0, 30, 31, 104);
    prog[5] = mk(1'b1, 32, 33, 105);
    prog[6] = mk(1'b0, 34, 35, 106);
    progLen = 7;
    runProg("arith");
    check(dmem[100] == 16'h0001 && dmem[101] == 16'hFFFF && dmem[102] == 16'h1000,
          "R1", "wrap values", {dmem[100], dmem[101]}, 32'h0001_FFFF);
  endtask

  task automatic tRaw();
    seedData(2);
    prog[0] = mk(1'b0, 1, 2, 3);
    prog[1] = mk(1'b0, 3, 3, 4);    // distance 1 on both operands
    prog[2] = mk(1'b1, 4, 3, 5);    // a at distance 1, b at distance 2
    prog[3] = mk(1'b0, 3, 5, 6);    // a at distance 3, b at distance 1
    prog[4] = mk(1'b1, 6, 3, 7);    // b at distance 4
    prog[5] = mk(1'b0, 9, 5, 8);    // b at distance 3
    prog[6] = mk(1'b0, 7, 8, 3);
    prog[7] = mk(1'b1, 3, 6, 9);
    progLen = 8;
    runProg("raw chain R4");
  endtask

  task automatic tWaw();
    seedData(3);
    prog[0] = mk(1'b0, 1, 2, 9);
    prog[1] = mk(1'b1, 1, 2, 9);    // overwrite at distance 1 (R5)
    prog[2] = mk(1'b0, 9, 9, 9);    // same address for A, B and C
    prog[3] = mk(1'b0, 9, 1, 9);
    prog[4] = mk(1'b1, 10, 11, 12);
    prog[5] = mk(1'b0, 13, 14, 12);
    progLen = 6;
    runProg("waw R5");
  endtask

  task automatic tHaltFirst();
    seedData(4);
    progLen = 0;
    runProg("halt at 0 R6");
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    tReset();
    tArith();
    tRaw();
    tWaw();
    tHaltFirst();
    tRaw();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule